// File: doc/BRIEF.md
# Configurable UART Character Transmitter

This block turns one parallel character into an asynchronous serial frame on a line that idles high. A character is offered on a valid/ready handshake together with a line-control byte. At the moment the character is accepted, the control byte sets three things for the frame: the word length, the parity mode and the stop period. The block is timed by a single-cycle enable that pulses sixteen times per bit period. That enable comes from an external baud-rate generator.

A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period of 1, 1.5 or 2 bit times. The parity bit can be odd, even, or stuck at mark or space. While a frame is on the line, `busy` is high and `tx_ready` is low. The block takes a new character in the cycle after the last stop tick.

Top module: `uart_char_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `tx_ready` is 1.
- R2: A character is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle, `txd` is 0 (the start bit) and `busy` is 1. The start bit lasts 16 ticks of `tick16`.
- R3: `line_ctl[1:0]` gives the word length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits. The data bits follow the start bit, least significant bit first, and each lasts 16 ticks. Bits of `tx_data` above the word length are never sent.
- R4: When `line_ctl[3]` is 0, no parity bit is sent and the stop period follows the last data bit directly.
- R5: When `line_ctl[3]` is 1 and `line_ctl[5]` is 0, a 16-tick parity bit follows the data bits. With `line_ctl[4]` = 0 it makes the count of ones across the sent data bits and the parity bit odd. With `line_ctl[4]` = 1 it makes that count even.
- R6: When `line_ctl[3]` is 1 and `line_ctl[5]` is 1, the parity bit is 1 if `line_ctl[4]` is 0 and 0 if `line_ctl[4]` is 1, whatever the data.
- R7: When `line_ctl[2]` is 0, the stop period is high for 16 ticks at every word length.
- R8: When `line_ctl[2]` is 1 and the word length is 5, the stop period is high for 24 ticks.
- R9: When `line_ctl[2]` is 1 and the word length is 6, 7 or 8, the stop period is high for 32 ticks.
- R10: `line_ctl` and `tx_data` are sampled only at acceptance. Changing them during a frame has no effect on that frame.
- R11: On the clock edge of the last stop tick, the block returns to idle, so `tx_ready` is 1 in the next cycle. `tx_valid` is ignored while `busy` is 1. A character held valid across a frame is accepted in the first idle cycle.
- R12: While `busy` is 1, `txd` changes only on a clock edge where `tick16` was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulsing 16 times per bit period |
| line_ctl | input | 8 | Frame format byte: word length, stop period, parity |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Block can accept a character |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |

## Verification
Frames are sent with every word length and every combination of stop length and parity mode. Each data value is chosen so that odd and even parity give different bits. A value with bits set above the word length shows whether parity counts bits that are never sent. The tick enable is run at one, two and three clock cycles per tick. This separates counting ticks from counting clocks, and exposes any change of `txd` between ticks. One frame has its control byte and data inverted in mid-frame, which checks that the format is captured at acceptance. A back-to-back pair with `tx_valid` held high checks that input is ignored while busy and that the next frame starts in the first cycle after the last stop tick.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_W = 8;
  localparam int CTL_W  = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PARITY, PH_STOP
  } phase_t;

  // stop code: 0 = one bit, 1 = one and a half, 2 = two
  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic       par_val;
    logic [1:0] stop_code;
  } frame_cfg_t;

  function automatic logic [3:0] word_len(input logic [CTL_W-1:0] ctl);
    return 4'd5 + {2'b00, ctl[1:0]};
  endfunction

  function automatic logic [1:0] stop_code(input logic [CTL_W-1:0] ctl);
    if (!ctl[2])              return 2'd0;
    else if (ctl[1:0] == 2'b00) return 2'd1;
    else                      return 2'd2;
  endfunction

  function automatic logic parity_value(input logic [CTL_W-1:0] ctl,
                                        input logic [DATA_W-1:0] data);
    logic [DATA_W-1:0] mask;
    logic ones_odd;
    mask     = ~(DATA_W'({DATA_W{1'b1}}) << word_len(ctl));
    ones_odd = ^(data & mask);
    if (ctl[5]) return ~ctl[4];            // stuck mark / space
    else        return ctl[4] ? ones_odd : ~ones_odd;
  endfunction

  function automatic frame_cfg_t build_cfg(input logic [CTL_W-1:0] ctl,
                                           input logic [DATA_W-1:0] data);
    frame_cfg_t c;
    c.nbits     = word_len(ctl);
    c.par_en    = ctl[3];
    c.par_val   = parity_value(ctl, data);
    c.stop_code = stop_code(ctl);
    return c;
  endfunction

endpackage

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       run,
  input  logic       tick,
  input  logic       in_stop,
  input  logic [1:0] stop_code,
  output logic       bit_done
);
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);
  localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
  localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * TICKS_PER_BIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = LIM_ONE;
    if (in_stop) begin
      case (stop_code)
        2'd1:    limit = LIM_HALF;
        2'd2:    limit = LIM_TWO;
        default: limit = LIM_ONE;
      endcase
    end
  end

  assign bit_done = run && tick && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear || bit_done) cnt_q <= '0;
    else if (run && tick)      cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              shift,
  output logic              lsb
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {1'b0, sh_q[DATA_W-1:1]};
  end

  assign lsb = sh_q[0];
endmodule

// File: rtl/utx_sequencer.sv
module utx_sequencer
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       bit_done,
  input  frame_cfg_t cfg,
  output phase_t     phase,
  output logic       shift_en,
  output logic       frame_done
);
  phase_t     ph_q;
  logic [2:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      left_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE:  if (accept) ph_q <= PH_START;
        PH_START: if (bit_done) begin
          ph_q   <= PH_DATA;
          left_q <= 3'(cfg.nbits - 4'd1);
        end
        PH_DATA:  if (bit_done) begin
          if (left_q == 3'd0) ph_q <= cfg.par_en ? PH_PARITY : PH_STOP;
          else                left_q <= left_q - 3'd1;
        end
        PH_PARITY: if (bit_done) ph_q <= PH_STOP;
        PH_STOP:   if (bit_done) ph_q <= PH_IDLE;
        default:   ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = ph_q;
  assign shift_en   = bit_done && (ph_q == PH_DATA);
  assign frame_done = bit_done && (ph_q == PH_STOP);
endmodule

// File: rtl/uart_char_tx.sv
module uart_char_tx
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic [CTL_W-1:0]  line_ctl,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  output logic              busy
);
  // named internal events, used by the bound checker
  logic       accept;
  logic       bit_done;
  logic       shift_en;
  logic       frame_done;
  logic       in_stop;
  logic       data_lsb;
  phase_t     phase;
  frame_cfg_t cfg_q;

  assign tx_ready = (phase == PH_IDLE);
  assign busy     = ~tx_ready;
  assign accept   = tx_valid && tx_ready;
  assign in_stop  = (phase == PH_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= build_cfg('0, '0);
    else if (accept) cfg_q <= build_cfg(line_ctl, tx_data);
  end

  utx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .run       (busy),
    .tick      (tick16),
    .in_stop   (in_stop),
    .stop_code (cfg_q.stop_code),
    .bit_done  (bit_done)
  );

  utx_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .din   (tx_data),
    .shift (shift_en),
    .lsb   (data_lsb)
  );

  utx_sequencer seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .bit_done   (bit_done),
    .cfg        (cfg_q),
    .phase      (phase),
    .shift_en   (shift_en),
    .frame_done (frame_done)
  );

  always_comb begin
    case (phase)
      PH_START:  txd = 1'b0;
      PH_DATA:   txd = data_lsb;
      PH_PARITY: txd = cfg_q.par_val;
      default:   txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_char_tx_chk.sv
module uart_char_tx_chk
  import uart_tx_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick16,
  input logic                         txd,
  input logic                         busy,
  input logic                         tx_ready,
  input logic                         accept,
  input logic                         frame_done,
  input logic                         in_stop,
  input logic [$bits(frame_cfg_t)-1:0] cfg_bits
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R1

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!txd && busy)); // R2

  AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> txd); // R7

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> $stable(cfg_bits)); // R10

  AST_DONE_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (tx_ready && !busy && txd)); // R11

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick16) |=> $stable(txd)); // R12
endmodule

bind uart_char_tx uart_char_tx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick16     (tick16),
  .txd        (txd),
  .busy       (busy),
  .tx_ready   (tx_ready),
  .accept     (accept),
  .frame_done (frame_done),
  .in_stop    (in_stop),
  .cfg_bits   (cfg_q)
);

// File: tb/uart_char_tx_tb_top.sv
`timescale 1ns/1ps
module uart_char_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [7:0] line_ctl = 8'h00;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txd, busy;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;   // 125 MHz

  uart_char_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_ctl(line_ctl),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txd(txd), .busy(busy)
  );

  // tick enable generator
  int tick_period = 1;
  int tick_cnt = 0;
  always @(negedge clk) begin
    if (tick_cnt >= tick_period - 1) begin tick16 <= 1'b1; tick_cnt <= 0; end
    else begin tick16 <= 1'b0; tick_cnt <= tick_cnt + 1; end
  end

  // behavioural reference: queue of line segments (level, ticks, tag)
  bit    seg_val[$];
  int    seg_ticks[$];
  string seg_tag[$];
  int    rem = 0;
  bit    m_accepted = 0;
  bit    last_tick = 0;
  bit    mid_change = 0;

  task automatic push_seg(bit v, int t, string tg);
    seg_val.push_back(v); seg_ticks.push_back(t); seg_tag.push_back(tg);
  endtask

  task automatic build_frame(logic [7:0] ctl, logic [7:0] d);
    int nb, ones, stop_t;
    bit pv;
    nb = 5 + int'(ctl[1:0]);
    ones = 0;
    push_seg(1'b0, 16, "R2");
    for (int i = 0; i < nb; i++) begin
      push_seg(d[i], 16, "R3");
      if (d[i]) ones++;
    end
    if (ctl[3]) begin
      if (ctl[5]) pv = !ctl[4];
      else if (ctl[4]) pv = (ones % 2 == 1);   // even total
      else pv = (ones % 2 == 0);               // odd total
      push_seg(pv, 16, ctl[5] ? "R6" : "R5");
    end
    if (!ctl[2]) stop_t = 16;
    else stop_t = (nb == 5) ? 24 : 32;
    push_seg(1'b1, stop_t,
             !ctl[2] ? (ctl[3] ? "R7" : "R4") : ((nb == 5) ? "R8" : "R9"));
    rem = 16;
  endtask

  always @(posedge clk) begin
    m_accepted = 0;
    last_tick = tick16;
    if (!rst_n) begin
      seg_val.delete(); seg_ticks.delete(); seg_tag.delete(); rem = 0;
    end else if (seg_val.size() == 0) begin
      if (tx_valid) begin
        build_frame(line_ctl, tx_data);
        m_accepted = 1;
      end
    end else if (tick16) begin
      rem--;
      if (rem == 0) begin
        void'(seg_val.pop_front()); void'(seg_ticks.pop_front());
        void'(seg_tag.pop_front());
        if (seg_ticks.size() != 0) rem = seg_ticks[0];
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit eb, ev;
    string tg;
    if (rst_n) begin
      eb = (seg_val.size() != 0);
      ev = eb ? seg_val[0] : 1'b1;
      if (!eb) tg = "R11";
      else if (!last_tick) tg = "R12";
      else tg = seg_tag[0];
      if (mid_change) tg = {"R10/", tg};
      n_cmp++;
      if (txd !== ev || busy !== eb || tx_ready !== !eb) begin
        n_bad++;
        $display("FAIL %s t=%0t txd/busy/ready act=%b%b%b exp=%b%b%b",
                 tg, $time, txd, busy, tx_ready, ev, eb, !eb);
      end
    end
  end

  task automatic wait_accept();
    do begin @(posedge clk); #1; end while (!m_accepted);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (seg_val.size() != 0);
  endtask

  task automatic send(logic [7:0] ctl, logic [7:0] d, int period, bit change);
    @(negedge clk);
    tick_period = period;
    line_ctl = ctl; tx_data = d; tx_valid = 1'b1;
    wait_accept();
    @(negedge clk);
    tx_valid = 1'b0;
    if (change) begin
      mid_change = 1;
      repeat (40) @(negedge clk);
      line_ctl = ~ctl; tx_data = ~d;
    end
    wait_idle();
    mid_change = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;   // R1: reset state
    if (txd !== 1'b1 || busy !== 1'b0 || tx_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 reset act=%b%b%b exp=101", txd, busy, tx_ready);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    send(8'h00, 8'h15, 1, 0);   // R3 R4 R7: 5 bits, no parity
    send(8'h03, 8'hA5, 2, 0);   // 8 bits, no parity
    send(8'h0B, 8'h5A, 1, 0);   // R5 odd, even ones
    send(8'h0B, 8'h5B, 3, 0);   // R5 odd, odd ones
    send(8'h1B, 8'h5A, 1, 0);   // R5 even
    send(8'h1B, 8'h01, 2, 0);   // R5 even, odd ones
    send(8'h2B, 8'h00, 1, 0);   // R6 mark
    send(8'h3B, 8'hFF, 1, 0);   // R6 space
    send(8'h04, 8'h1F, 1, 0);   // R8 1.5 stop
    send(8'h0C, 8'hE3, 3, 0);   // R8 with parity, high bits unsent
    send(8'h05, 8'h2A, 1, 0);   // R9 6 bits
    send(8'h06, 8'h55, 2, 0);   // R9 7 bits
    send(8'h07, 8'h81, 1, 0);   // R9 8 bits
    send(8'h1E, 8'h7E, 1, 0);   // R9 7 bits even parity
    send(8'h09, 8'hC1, 2, 0);   // 6 bits odd, high bits ignored
    send(8'h08, 8'hFF, 1, 0);   // 5 bits odd, high bits excluded
    send(8'h0B, 8'h3C, 1, 1);   // R10 mid-frame change

    // R11: valid held across a frame, second character follows at once
    @(negedge clk);
    tick_period = 2;
    line_ctl = 8'h0F; tx_data = 8'h96; tx_valid = 1'b1;
    wait_accept();
    @(negedge clk);
    tx_data = 8'h69;
    wait_accept();
    @(negedge clk);
    tx_valid = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule